// File: doc/BRIEF.md
# Two-Port Parallel I/O Register Block

This block is the register side of a parallel I/O peripheral with two byte-wide ports, called A and B. A processor reaches it through a 16-byte window on a simple synchronous bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each port has an output latch and a direction mask. A direction bit of 1 turns the pin into an output that is driven from the latch. The block drives the latch value and an output enable onto every pin. Reading a port returns a per-pin mix: output pins give the latch bit, and input pins give the pin level sampled one clock earlier.

A control byte is stored for the peripheral. Seven interrupt sources come from outside as single-cycle event pulses, and each sets its own flag bit. The flags AND-ed with a seven-bit enable mask drive one interrupt request. The processor clears flags by writing 1s to them. It changes enables in set/clear form, where the top bit of the written byte chooses whether the 1 bits set or clear enables. A second address for the port A latch writes the same latch.

The low four address bits are decoded into one of nine select codes: NONE, OUT_B, OUT_A, DIR_B, DIR_A, CTRL, FLAG, ENA and OUT_A_NH. Every bus access is steered by that code. No access sequence or state machine is kept beyond the stored registers.

Top module: `pio_regblk`

## Requirements
- R1: After reset both output latches are 0xFF, both direction masks and all output enables are 0x00, the control byte is 0x00, all flags and enables are 0, and irq is 0.
- R2: Offset 0x0 writes the port B latch and offset 0x2 writes the port B direction mask. pb_out shows the latch and pb_oe shows the mask. Reading 0x0 returns the latch bits where the mask is 1 and the sampled pb_in bits where it is 0. Reading 0x2 returns the mask.
- R3: Offsets 0x1 (latch) and 0x3 (direction mask) behave for port A exactly as R2 describes for port B, using pa_in, pa_out and pa_oe.
- R4: A write to offset 0xF updates the port A latch exactly as a write to 0x1 does. Reading 0xF returns the same value as reading 0x1.
- R5: Offset 0xC is an 8-bit control byte that reads back the last value written to it.
- R6: A 1 on evt_set[i] for one cycle sets flag bit i. The flag then stays set until it is cleared by a bus write.
- R7: Writing offset 0xD clears every flag bit i (i = 0 to 6) whose written bit i is 1, and bit 7 of the written byte has no effect. If an event pulse and a clearing write reach the same bit in the same cycle, the flag is left set.
- R8: A write to offset 0xE with bit 7 = 1 sets each enable bit whose written bit is 1. With bit 7 = 0, it clears those bits instead. Enable bits written as 0 keep their value. Reading 0xE returns the enables in bits 6:0 and a 1 in bit 7.
- R9: irq is 1 exactly when some bit i has both its flag and its enable set. Reading 0xD returns the flags in bits 6:0 and the irq value in bit 7.
- R10: Reads of offsets 0x4 to 0xB return 0x00. Writes to them change no register.
- R11: bus_rdata takes the addressed value at the clock edge where bus_re is 1 and holds that value while bus_re is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data is valid the cycle after |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch value |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch value |
| pb_oe | output | 8 | Port B output enables |
| evt_set | input | 7 | Event pulses that set the flags |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench uses the default parameters: an 8-bit data width and a 4-bit address. With these values every one of the 16 offsets, including the unused gap, can be addressed. The flag field is then seven bits wide, so flag bit 7 reads as the summary bit. Fixed pin levels on both ports, together with partial direction masks, check the per-bit readback mix. The bench also puts an event pulse and a clearing write in the same cycle to check that the set wins.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT_B,
        SEL_OUT_A,
        SEL_DIR_B,
        SEL_DIR_A,
        SEL_CTRL,
        SEL_FLAG,
        SEL_ENA,
        SEL_OUT_A_NH
    } reg_sel_e;

    // Offsets are fixed by the bus map; bit 0 of the port offsets picks A (1) or B (0).
    function automatic reg_sel_e decode_sel(input logic [3:0] offs);
        reg_sel_e s;
        unique case (offs)
            4'h0:    s = SEL_OUT_B;
            4'h1:    s = SEL_OUT_A;
            4'h2:    s = SEL_DIR_B;
            4'h3:    s = SEL_DIR_A;
            4'hC:    s = SEL_CTRL;
            4'hD:    s = SEL_FLAG;
            4'hE:    s = SEL_ENA;
            4'hF:    s = SEL_OUT_A_NH;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pio_port.sv
module pio_port #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_out,
    input  logic          wr_dir,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] out_q,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] rd_val
);

    logic [DW-1:0] pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= {DW{1'b1}};
            dir_q <= '0;
            pin_q <= '0;
        end else begin
            pin_q <= pin_in;
            if (wr_out) out_q <= wdata;
            if (wr_dir) dir_q <= wdata;
        end
    end

    always_comb begin
        rd_val = (out_q & dir_q) | (pin_q & ~dir_q);
    end

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_q));

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(dir_q));

endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_flag,
    input  logic          wr_ena,
    input  logic [DW-1:0] wdata,
    input  logic [DW-2:0] evt_set,
    output logic [DW-1:0] flag_rd,
    output logic [DW-1:0] ena_rd,
    output logic          irq
);

    localparam int NF = DW - 1;

    logic [NF-1:0] flag_q;
    logic [NF-1:0] ena_q;
    logic [NF-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_flag ? wdata[NF-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            ena_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | evt_set;
            if (wr_ena) begin
                if (wdata[DW-1]) ena_q <= ena_q | wdata[NF-1:0];
                else             ena_q <= ena_q & ~wdata[NF-1:0];
            end
        end
    end

    always_comb begin
        irq     = |(flag_q & ena_q);
        flag_rd = {irq, flag_q};
        ena_rd  = {1'b1, ena_q};
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((flag_q & $past(evt_set)) == $past(evt_set)));

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set == '0 && !wr_flag) |=> $stable(flag_q));

    p_ena_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ena |=> $stable(ena_q));

endmodule

// File: rtl/pio_regblk.sv
module pio_regblk
    import pio_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_we,
    input  logic          bus_re,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-2:0] evt_set,
    output logic          irq
);

    localparam int NPORT  = 2;
    localparam int PORT_B = 0;
    localparam int PORT_A = 1;

    reg_sel_e sel;
    logic [NPORT-1:0]         wr_out;
    logic [NPORT-1:0]         wr_dir;
    logic [NPORT-1:0][DW-1:0] pin_v;
    logic [NPORT-1:0][DW-1:0] out_v;
    logic [NPORT-1:0][DW-1:0] dir_v;
    logic [NPORT-1:0][DW-1:0] rd_v;
    logic [DW-1:0]            ctrl_q;
    logic [DW-1:0]            flag_rd;
    logic [DW-1:0]            ena_rd;
    logic [DW-1:0]            rd_mux;

    assign sel = decode_sel(bus_addr[3:0]);

    always_comb begin
        wr_out[PORT_B] = bus_we && (sel == SEL_OUT_B);
        wr_out[PORT_A] = bus_we && (sel == SEL_OUT_A || sel == SEL_OUT_A_NH);
        wr_dir[PORT_B] = bus_we && (sel == SEL_DIR_B);
        wr_dir[PORT_A] = bus_we && (sel == SEL_DIR_A);
    end

    assign pin_v[PORT_B] = pb_in;
    assign pin_v[PORT_A] = pa_in;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pio_port #(.DW(DW)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_out (wr_out[p]),
            .wr_dir (wr_dir[p]),
            .wdata  (bus_wdata),
            .pin_in (pin_v[p]),
            .out_q  (out_v[p]),
            .dir_q  (dir_v[p]),
            .rd_val (rd_v[p])
        );
    end

    assign pb_out = out_v[PORT_B];
    assign pb_oe  = dir_v[PORT_B];
    assign pa_out = out_v[PORT_A];
    assign pa_oe  = dir_v[PORT_A];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (bus_we && sel == SEL_CTRL) ctrl_q <= bus_wdata;
    end

    pio_irq #(.DW(DW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_flag (bus_we && sel == SEL_FLAG),
        .wr_ena  (bus_we && sel == SEL_ENA),
        .wdata   (bus_wdata),
        .evt_set (evt_set),
        .flag_rd (flag_rd),
        .ena_rd  (ena_rd),
        .irq     (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_OUT_B:    rd_mux = rd_v[PORT_B];
            SEL_OUT_A:    rd_mux = rd_v[PORT_A];
            SEL_OUT_A_NH: rd_mux = rd_v[PORT_A];
            SEL_DIR_B:    rd_mux = dir_v[PORT_B];
            SEL_DIR_A:    rd_mux = dir_v[PORT_A];
            SEL_CTRL:     rd_mux = ctrl_q;
            SEL_FLAG:     rd_mux = flag_rd;
            SEL_ENA:      rd_mux = ena_rd;
            SEL_NONE:     rd_mux = '0;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[3:0] >= 4'h4 && bus_addr[3:0] <= 4'hB) |=> (bus_rdata == '0));

    p_alias_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:0] == 4'hF) |=> (pa_out == $past(bus_wdata)));

    p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:0] == 4'hE && bus_wdata == {1'b0, {(DW-1){1'b1}}}) |=> !irq);

endmodule

// File: tb/pio_regblk_tb.sv
`timescale 1ns/1ps
module pio_regblk_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h5A;
    logic [7:0] pa_out, pa_oe;
    logic [7:0] pb_in = 8'hC3;
    logic [7:0] pb_out, pb_oe;
    logic [6:0] evt_set = '0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pio_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .evt_set(evt_set), .irq(irq)
    );

    // {req[3:0], is_write, addr[3:0], data[7:0], expected[7:0]}
    localparam int NV = 26;
    localparam logic [24:0] VEC [NV] = '{
        {4'd5,  1'b1, 4'hC, 8'hA5, 8'h00},   // R5 store control
        {4'd5,  1'b0, 4'hC, 8'h00, 8'hA5},   // R5 read back
        {4'd2,  1'b0, 4'h0, 8'h00, 8'hC3},   // R2 all inputs
        {4'd2,  1'b1, 4'h2, 8'h0F, 8'h00},
        {4'd2,  1'b1, 4'h0, 8'h12, 8'h00},
        {4'd2,  1'b0, 4'h0, 8'h00, 8'hC2},   // R2 mixed readback
        {4'd3,  1'b1, 4'h3, 8'hF0, 8'h00},
        {4'd3,  1'b1, 4'h1, 8'h33, 8'h00},
        {4'd3,  1'b0, 4'h1, 8'h00, 8'h3A},   // R3 mixed readback
        {4'd3,  1'b0, 4'h3, 8'h00, 8'hF0},   // R3 mask readback
        {4'd2,  1'b0, 4'h2, 8'h00, 8'h0F},   // R2 mask readback
        {4'd4,  1'b1, 4'hF, 8'hCC, 8'h00},   // R4 alias write
        {4'd4,  1'b0, 4'h1, 8'h00, 8'hCA},
        {4'd4,  1'b0, 4'hF, 8'h00, 8'hCA},
        {4'd10, 1'b1, 4'h5, 8'hFF, 8'h00},   // R10 write into the gap
        {4'd10, 1'b0, 4'h5, 8'h00, 8'h00},
        {4'd10, 1'b0, 4'hB, 8'h00, 8'h00},
        {4'd10, 1'b0, 4'hC, 8'h00, 8'hA5},
        {4'd10, 1'b0, 4'h0, 8'h00, 8'hC2},
        {4'd8,  1'b1, 4'hE, 8'h85, 8'h00},   // R8 set bits 0,2
        {4'd8,  1'b0, 4'hE, 8'h00, 8'h85},
        {4'd8,  1'b1, 4'hE, 8'h04, 8'h00},   // R8 clear bit 2
        {4'd8,  1'b0, 4'hE, 8'h00, 8'h81},
        {4'd8,  1'b1, 4'hE, 8'h80, 8'h00},   // R8 set nothing
        {4'd8,  1'b0, 4'hE, 8'h00, 8'h81},
        {4'd6,  1'b0, 4'hD, 8'h00, 8'h00}    // R6 no flags yet
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pa_out", pa_out, 8'hFF);
        check("R1 pa_oe", pa_oe, 8'h00);
        check("R1 pb_out", pb_out, 8'hFF);
        check("R1 pb_oe", pb_oe, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(4'hC, v); check("R1 ctrl", v, 8'h00);
        rd(4'hD, v); check("R1 flags", v, 8'h00);
        rd(4'hE, v); check("R1 enables", v, 8'h80);
        rd(4'h1, v); check("R1 port A reads pins", v, 8'h5A);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) begin
                wr(VEC[i][19:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][19:16], v);
                check($sformatf("R%0d vector %0d", VEC[i][24:21], i), v, VEC[i][7:0]);
            end
        end

        check("R2 pb_out", pb_out, 8'h12);
        check("R2 pb_oe", pb_oe, 8'h0F);
        check("R3 pa_oe", pa_oe, 8'hF0);
        check("R4 pa_out after alias", pa_out, 8'hCC);

        // enables now 0x01
        pulse(7'h02);
        check("R9 unmasked flag gives no irq", {7'd0, irq}, 8'h00);
        rd(4'hD, v); check("R6 flag 1 set", v, 8'h02);
        pulse(7'h01);
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        rd(4'hD, v); check("R9 summary bit", v, 8'h83);
        wr(4'hD, 8'h81);
        check("R7 irq dropped after clear", {7'd0, irq}, 8'h00);
        rd(4'hD, v); check("R7 clear bit 0 only", v, 8'h02);

        // R7 collision: set and clear same bit in one cycle
        @(negedge clk);
        bus_addr = 4'hD; bus_wdata = 8'h06; bus_we = 1'b1; evt_set = 7'h02;
        @(negedge clk);
        bus_we = 1'b0; evt_set = '0;
        rd(4'hD, v); check("R7 set wins", v, 8'h02);
        wr(4'hD, 8'h7F);
        rd(4'hD, v); check("R7 clear all", v, 8'h00);

        pulse(7'h40);
        check("R9 bit 6 masked", {7'd0, irq}, 8'h00);
        wr(4'hE, 8'hC0);
        check("R9 bit 6 enabled", {7'd0, irq}, 8'h01);
        wr(4'hE, 8'h7F);
        check("R9 all masked", {7'd0, irq}, 8'h00);
        rd(4'hE, v); check("R8 all cleared", v, 8'h80);

        // R11 read data holds with bus_re low
        rd(4'hC, held);
        wr(4'hC, 8'h11);
        repeat (2) @(negedge clk);
        check("R11 rdata held", bus_rdata, held);
        rd(4'hC, v); check("R5 new control", v, 8'h11);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule